// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources for a small CPU core and turns them into one request line with a vector address. The sources are two active-low external pins, two timer overflow pulses and a serial port. The controller keeps the request flags for the pins and the timers. It applies a master enable and a per-source enable. It sorts the enabled requests into a high and a low priority level, and it tracks which levels are in service so that service routines can nest.

The CPU watches `irq_req` and reads `irq_vec`. It pulses `ack` for one cycle when it takes the vector. When the service routine finishes, it pulses `reti` for one cycle. Timer and edge flags are cleared by the acknowledge. The serial request and level-sensed pins are not latched here: they stay asserted for as long as their inputs remain active.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is low and all pin and timer request flags are clear.
- R2: A source can request only when `glb_en` is 1 and its bit of `src_en` is 1. The bit order is 0 = pin 0, 1 = timer 0, 2 = pin 1, 3 = timer 1, 4 = serial.
- R3: `irq_vec` is 0x03, 0x0B, 0x13, 0x1B or 0x23 for source index 0, 1, 2, 3 or 4 respectively.
- R4: When several sources at the same level are eligible, the one with the lowest index wins.
- R5: A source whose bit in `src_hi` is 1 is high level. A high-level source wins over any low-level source, whatever their indices.
- R6: While low-level service is active, only high-level sources may request. While high-level service is active, no source may request.
- R7: A `reti` pulse ends high-level service if it is active, and otherwise ends low-level service.
- R8: An acknowledge clears the timer flag of the acknowledged source. A timer pulse sets that flag and wins over a clear in the same cycle.
- R9: When `ext_edge` bit i is 0, pin i requests while it is low. The request follows the pin three clock edges later, and an acknowledge does not remove it.
- R10: The serial source requests while `ser_rx` or `ser_tx` is 1. An acknowledge does not clear it.
- R11: When `ext_edge` bit i is 1, a falling edge on pin i sets its flag on the third clock edge after the change. The acknowledge clears the flag. A pin that stays low does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | Asynchronous external request pins, active low |
| ext_edge | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | Timer overflow pulses (timer 0, timer 1) |
| ser_rx | input | 1 | Serial receive-done flag |
| ser_tx | input | 1 | Serial transmit-done flag |
| glb_en | input | 1 | Master interrupt enable |
| src_en | input | 5 | Per-source enables |
| src_hi | input | 5 | Per-source level, 1 = high |
| ack | input | 1 | CPU took the vector |
| reti | input | 1 | Return from service routine |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 8 | Vector address of the winning source |

## Verification
A wrong service-level bit shows up in the first cycle a request is eligible. It appears either as a request that should be masked or as a missing preemption, so the bench compares `irq_req` and `irq_vec` against a model on every cycle. A stuck or wrongly cleared flag shows at the ports once the service level allows requests again, which is one `reti` later. A synchronizer stage that is off by one moves the appearance of a pin request by a cycle, and the cycle-exact pin checks catch it.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int VW = 8,
  parameter int VBASE = 3,
  parameter int VSTEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ext_n,
  input  logic [1:0]    ext_edge,
  input  logic [1:0]    tmr_ovf,
  input  logic          ser_rx,
  input  logic          ser_tx,
  input  logic          glb_en,
  input  logic [4:0]    src_en,
  input  logic [4:0]    src_hi,
  input  logic          ack,
  input  logic          reti,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  localparam int NS = 5;

  logic [1:0] s1, s2, s3, ie_q, tf_q;
  logic act_hi, act_lo;
  logic [2:0] sel;

  wire [1:0]    fall    = s3 & ~s2;
  wire [NS-1:0] src     = {ser_rx | ser_tx, tf_q[1], ie_q[1], tf_q[0], ie_q[0]};
  wire [NS-1:0] elig    = src & src_en & {NS{glb_en}};
  wire [NS-1:0] cand_hi = act_hi ? '0 : (elig & src_hi);
  wire [NS-1:0] cand_lo = (act_hi | act_lo) ? '0 : (elig & ~src_hi);
  wire          sel_hi  = |cand_hi;
  wire [NS-1:0] pool    = sel_hi ? cand_hi : cand_lo;
  wire          take    = ack & irq_req;

  always_comb begin
    sel = 3'd0;
    for (int i = NS - 1; i >= 0; i--)
      if (pool[i]) sel = 3'(i);
  end

  assign irq_req = |pool;
  assign irq_vec = VW'(VBASE + VSTEP * int'(sel));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11;
      s2 <= 2'b11;
      s3 <= 2'b11;
    end else begin
      s1 <= ext_n;
      s2 <= s1;
      s3 <= s2;
    end

  for (genvar i = 0; i < 2; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ie_q[i] <= 1'b0;
      else if (!ext_edge[i]) ie_q[i] <= ~s2[i];
      else if (fall[i]) ie_q[i] <= 1'b1;
      else if (take && sel == 3'(2*i)) ie_q[i] <= 1'b0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tf_q[i] <= 1'b0;
      else if (tmr_ovf[i]) tf_q[i] <= 1'b1;
      else if (take && sel == 3'(2*i+1)) tf_q[i] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else if (take) begin
      if (sel_hi) act_hi <= 1'b1;
      else act_lo <= 1'b1;
    end else if (reti) begin
      if (act_hi) act_hi <= 1'b0;
      else act_lo <= 1'b0;
    end

  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glb_en);
  a_r3_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((int'(irq_vec) - VBASE) % VSTEP == 0));
  a_r6_enter_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_hi) |=> act_hi);
  a_r6_enter_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sel_hi) |=> act_lo);
  a_r7_reti_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && act_hi) |=> (!act_hi && $stable(act_lo)));
  a_r8_tf0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel == 3'd1 && !tmr_ovf[0]) |=> !tf_q[0]);
  a_r11_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge[0] && fall[0]) |=> ie_q[0]);
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
  logic ser_rx = 0, ser_tx = 0, glb_en = 0, ack = 0, reti = 0;
  logic [4:0] src_en = 5'h1F, src_hi = 5'h00;
  logic irq_req;
  logic [7:0] irq_vec;
  int errors = 0, checks = 0;
  bit done = 0;

  bit [1:0] ms1, ms2, ms3, mie, mtf;
  bit mhi, mlo;

  always #5 clk = ~clk;

  irq_ctrl u0 (.clk, .rst_n, .ext_n, .ext_edge, .tmr_ovf, .ser_rx, .ser_tx,
               .glb_en, .src_en, .src_hi, .ack, .reti, .irq_req, .irq_vec);

  function automatic bit [4:0] m_elig();
    bit [4:0] s = {ser_rx | ser_tx, mtf[1], mie[1], mtf[0], mie[0]};
    return s & src_en & {5{glb_en}};
  endfunction

  task automatic m_eval(output bit r, output int idx, output bit hi);
    bit [4:0] e = m_elig();
    bit [4:0] h = mhi ? 5'b0 : (e & src_hi);
    bit [4:0] l = (mhi | mlo) ? 5'b0 : (e & ~src_hi);
    bit [4:0] p = (h != 0) ? h : l;
    r = (p != 0); hi = (h != 0); idx = 0;
    for (int i = 4; i >= 0; i--) if (p[i]) idx = i;
  endtask

  task automatic cyc(input string tag);
    bit r, hi, ta; int idx;
    bit [1:0] nie, ntf;
    #1;
    m_eval(r, idx, hi);
    checks++;
    if (irq_req !== r || (r && irq_vec !== 8'(3 + 8*idx))) begin
      errors++;
      $display("FAIL %s: req=%b vec=%h expected req=%b vec=%h", tag, irq_req, irq_vec, r, 8'(3 + 8*idx));
    end
    ta = ack && r;
    for (int i = 0; i < 2; i++) begin
      nie[i] = mie[i]; ntf[i] = mtf[i];
      if (!ext_edge[i]) nie[i] = ~ms2[i];
      else if (ms3[i] && !ms2[i]) nie[i] = 1;
      else if (ta && idx == 2*i) nie[i] = 0;
      if (tmr_ovf[i]) ntf[i] = 1;
      else if (ta && idx == 2*i+1) ntf[i] = 0;
    end
    if (ta) begin if (hi) mhi = 1; else mlo = 1; end
    else if (reti) begin if (mhi) mhi = 0; else mlo = 0; end
    mie = nie; mtf = ntf;
    ms3 = ms2; ms2 = ms1; ms1 = ext_n;
    @(negedge clk);
    ack = 0; reti = 0; tmr_ovf = 0;
  endtask

  task automatic expect_vec(input string tag, input logic [7:0] v);
    #1; checks++;
    if (irq_req !== 1'b1 || irq_vec !== v) begin
      errors++;
      $display("FAIL %s: req=%b vec=%h expected req=1 vec=%h", tag, irq_req, irq_vec, v);
    end
  endtask

  task automatic expect_none(input string tag);
    #1; checks++;
    if (irq_req !== 1'b0) begin
      errors++;
      $display("FAIL %s: req=%b expected req=0", tag, irq_req);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    ms1 = 2'b11; ms2 = 2'b11; ms3 = 2'b11; mie = 0; mtf = 0; mhi = 0; mlo = 0;
    repeat (3) @(negedge clk);
    expect_none("R1");
    rst_n = 1;
    cyc("R1"); cyc("R1");
    expect_none("R1");

    tmr_ovf = 2'b01; cyc("R2");
    repeat (3) cyc("R2");
    expect_none("R2");
    glb_en = 1;
    expect_vec("R3", 8'h0B);
    ack = 1; cyc("R8");
    reti = 1; cyc("R7");
    expect_none("R8");

    tmr_ovf = 2'b11; ser_rx = 1; cyc("R4");
    expect_vec("R4", 8'h0B);
    ack = 1; cyc("R4");
    expect_none("R6");
    reti = 1; cyc("R7");
    expect_vec("R4", 8'h1B);
    ack = 1; cyc("R4");
    reti = 1; cyc("R7");
    expect_vec("R10", 8'h23);
    ack = 1; cyc("R10");
    reti = 1; cyc("R10");
    expect_vec("R10", 8'h23);
    ser_rx = 0; ser_tx = 1;
    expect_vec("R10", 8'h23);
    ser_tx = 0; cyc("R10");
    expect_none("R10");

    src_hi = 5'b10000; tmr_ovf = 2'b01; ser_rx = 1; cyc("R5");
    expect_vec("R5", 8'h23);
    ack = 1; cyc("R6");
    expect_none("R6");
    ser_rx = 0; reti = 1; cyc("R7");
    expect_vec("R7", 8'h0B);
    ack = 1; cyc("R6");
    ser_rx = 1;
    expect_vec("R6", 8'h23);
    ack = 1; cyc("R6");
    expect_none("R6");
    reti = 1; cyc("R7");
    expect_vec("R7", 8'h23);
    ser_rx = 0; cyc("R7");
    expect_none("R7");
    reti = 1; cyc("R7");
    src_hi = 0;

    ext_edge = 2'b11; ext_n = 2'b10;
    cyc("R11"); cyc("R11");
    expect_none("R11");
    cyc("R11");
    expect_vec("R11", 8'h03);
    ack = 1; cyc("R11");
    reti = 1; cyc("R11");
    repeat (3) cyc("R11");
    expect_none("R11");
    ext_n = 2'b11; repeat (3) cyc("R11");

    ext_edge = 2'b01; ext_n = 2'b01;
    repeat (3) cyc("R9");
    expect_vec("R9", 8'h13);
    ack = 1; cyc("R9");
    reti = 1; cyc("R9");
    expect_vec("R9", 8'h13);
    ext_n = 2'b11; repeat (3) cyc("R9");
    expect_none("R9");

    for (int n = 0; n < 4000; n++) begin
      bit r, hi; int idx;
      if ($urandom % 16 == 0) ext_n[$urandom % 2] ^= 1'b1;
      if ($urandom % 64 == 0) ext_edge = 2'($urandom);
      tmr_ovf = {($urandom % 8 == 0), ($urandom % 8 == 0)};
      if ($urandom % 10 == 0) ser_rx = ~ser_rx;
      if ($urandom % 12 == 0) ser_tx = ~ser_tx;
      if ($urandom % 50 == 0) glb_en = ($urandom % 5 != 0);
      if ($urandom % 40 == 0) src_en = 5'($urandom);
      if ($urandom % 40 == 0) src_hi = 5'($urandom);
      #1;
      m_eval(r, idx, hi);
      ack = r && ($urandom % 2 == 0);
      reti = !ack && (mhi || mlo) && ($urandom % 5 == 0);
      cyc("R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule